// File: doc/BRIEF.md
# Interrupt Entry and Status Unit

This block is the interrupt side of a small system-control coprocessor for a pipelined 32-bit core. It holds three pieces of state:

- an 8-bit interrupt mask;
- a three-deep stack of interrupt-enable bits (current, previous, old);
- an exception return address, stored as a word address.

Each cycle the fetch stage gives it the word address it would fetch next. That address is either the sequential successor or a resolved jump target. The block decides whether an external interrupt is taken in that cycle. When it takes one, it sends fetch to a fixed handler address, saves the address that fetch would have used, and pushes a zero into the current-enable bit.

The decode stage marks branch and jump delay slots. Interrupt entry is blocked in a marked cycle and in the cycle right after it, so that an interrupt never splits a branch from its delay slot. Software reaches the state in three ways:

- a status-register write strobe with a data word;
- a return-from-exception strobe, which pops the enable stack;
- three read buses for status, cause and the return address.

The pop and the status write are both applied in the same cycle as an interrupt entry. They take effect before the entry's push.

Top module: `irq_entry_unit`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), the status read, the return-address read and `redirect` are all zero.
- R2: `redirect` is high in a cycle exactly when all of these hold:
  - the bitwise AND of the registered mask and `irq_lines` is nonzero;
  - the registered current-enable bit is 1;
  - `hold`, `rst`, `delay_slot_mark` and the registered previous-cycle mark are all 0.
- R3: A status write (`sr_wr_en`) loads the mask from data bits 15:8, current enable from bit 0, previous enable from bit 2 and old enable from bit 4. All other data bits are ignored. The status read shows the same bits at the same positions and zeros elsewhere.
- R4: On an interrupt entry the enable stack is pushed: previous takes current, old takes previous, and current becomes 0. The return-address register takes `next_pc`.
- R5: `fetch_pc` equals the handler word address (byte address 0x200000C0, so word 0x08000030) in a cycle with `redirect` high. Otherwise it equals `next_pc`.
- R6: No interrupt entry happens in a cycle with `delay_slot_mark` high, nor in the cycle that follows it.
- R7: A return-from-exception strobe pops the enable stack: current takes previous, previous takes old, and old is unchanged. When it coincides with an entry, the pop is applied first and the push acts on the popped values.
- R8: When a status write coincides with an entry, the written values are stored first and the push acts on them.
- R9: The cause read returns `irq_lines` in bits 15:8 and zeros in all other bits.
- R10: The return-address read returns the stored word address with two zero bits appended below it.
- R11: While `hold` is high, no state changes and `redirect` stays low.
- R12: The entry decision uses the registered mask and enable bits. A status write in the same cycle affects decisions from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freeze all state, block interrupt entry |
| irq_lines | input | 8 | External interrupt request lines |
| next_pc | input | 30 | Word address fetch would use next (PC+1 or jump target) |
| delay_slot_mark | input | 1 | Decode marks a branch/jump delay slot this cycle |
| sr_wr_en | input | 1 | Status register write strobe |
| sr_wr_data | input | 32 | Status register write data |
| rfe_en | input | 1 | Return-from-exception strobe (pop enable stack) |
| redirect | output | 1 | Interrupt entry taken this cycle |
| fetch_pc | output | 30 | Word address fetch must use next |
| rd_status | output | 32 | Status register read data |
| rd_cause | output | 32 | Cause register read data |
| rd_epc | output | 32 | Return-address register read data |

## Verification
A corrupted mask or current-enable bit shows up at once on `rd_status`. It also changes the `redirect` decision in the same cycle that a matching request line rises. A wrong push or pop order lets a stale enable bit surface on `rd_status` on the edge after the entry or return. It can also let a second entry fire one cycle later than it should. A lost previous-cycle delay mark appears as a `redirect` exactly one cycle after a marked slot. A bad capture of the return address shows on `rd_epc` on the first cycle after the entry. The reference model compares every output on every cycle, so each of these faults is caught on the cycle it first becomes visible.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int IRQ_W      = 8;
    localparam int WORD_W     = 32;
    localparam int PCW        = WORD_W - 2;

    // Status word field positions
    localparam int SR_CUR_BIT  = 0;
    localparam int SR_PREV_BIT = 2;
    localparam int SR_OLD_BIT  = 4;
    localparam int SR_MASK_LSB = 8;
    localparam int SR_MASK_MSB = SR_MASK_LSB + IRQ_W - 1;

    // Cause word: raw request lines sit at the same place as the mask
    localparam int CAUSE_LSB   = SR_MASK_LSB;

    typedef struct packed {
        logic old_en;
        logic prev_en;
        logic cur_en;
    } ie_stack_t;

    typedef struct packed {
        logic [IRQ_W-1:0] mask;
        ie_stack_t        ie;
    } status_t;

    function automatic ie_stack_t ie_push(input ie_stack_t s);
        ie_stack_t r;
        r.old_en  = s.prev_en;
        r.prev_en = s.cur_en;
        r.cur_en  = 1'b0;
        return r;
    endfunction

    function automatic ie_stack_t ie_pop(input ie_stack_t s);
        ie_stack_t r;
        r.old_en  = s.old_en;
        r.prev_en = s.old_en;
        r.cur_en  = s.prev_en;
        return r;
    endfunction

    function automatic status_t sr_decode(input logic [WORD_W-1:0] d);
        status_t r;
        r.mask       = d[SR_MASK_MSB:SR_MASK_LSB];
        r.ie.cur_en  = d[SR_CUR_BIT];
        r.ie.prev_en = d[SR_PREV_BIT];
        r.ie.old_en  = d[SR_OLD_BIT];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] sr_encode(input status_t s);
        logic [WORD_W-1:0] r;
        r                          = '0;
        r[SR_MASK_MSB:SR_MASK_LSB] = s.mask;
        r[SR_CUR_BIT]              = s.ie.cur_en;
        r[SR_PREV_BIT]             = s.ie.prev_en;
        r[SR_OLD_BIT]              = s.ie.old_en;
        return r;
    endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_entry_pkg::*;
(
    input  logic             rst,
    input  logic             hold,
    input  logic [IRQ_W-1:0] mask,
    input  logic             cur_en,
    input  logic [IRQ_W-1:0] irq_lines,
    input  logic             mark_now,
    input  logic             mark_prev,
    output logic             take
);

    logic [IRQ_W-1:0] hit;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_line
        assign hit[i] = mask[i] & irq_lines[i];
    end

    logic pending;
    logic blocked;

    assign pending = (|hit) & cur_en;
    assign blocked = rst | hold | mark_now | mark_prev;
    assign take    = pending & ~blocked;

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              rfe_en,
    input  logic              sr_wr_en,
    input  logic [WORD_W-1:0] sr_wr_data,
    input  logic              take,
    output status_t           status_q
);

    status_t status_d;

    // Order inside one cycle: pop, then write, then push on entry.
    always_comb begin
        status_d = status_q;
        if (rfe_en) begin
            status_d.ie = ie_pop(status_d.ie);
        end
        if (sr_wr_en) begin
            status_d = sr_decode(sr_wr_data);
        end
        if (take) begin
            status_d.ie = ie_push(status_d.ie);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (!hold) begin
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/irq_epc_reg.sv
module irq_epc_reg
    import irq_entry_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           hold,
    input  logic           take,
    input  logic [PCW-1:0] next_pc,
    output logic [PCW-1:0] epc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q <= '0;
        end else if (!hold && take) begin
            epc_q <= next_pc;
        end
    end

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter logic [31:0] HANDLER_ADDR = 32'h2000_00C0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic [7:0]  irq_lines,
    input  logic [29:0] next_pc,
    input  logic        delay_slot_mark,
    input  logic        sr_wr_en,
    input  logic [31:0] sr_wr_data,
    input  logic        rfe_en,
    output logic        redirect,
    output logic [29:0] fetch_pc,
    output logic [31:0] rd_status,
    output logic [31:0] rd_cause,
    output logic [31:0] rd_epc
);

    localparam logic [PCW-1:0] HANDLER_WORD = HANDLER_ADDR[WORD_W-1:2];

    status_t        status_q;
    logic [PCW-1:0] epc_q;
    logic           mark_q;
    logic           take;

    // Delay-slot mark remembered for one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q <= 1'b0;
        end else if (!hold) begin
            mark_q <= delay_slot_mark;
        end
    end

    irq_gate u_gate (
        .rst       (rst),
        .hold      (hold),
        .mask      (status_q.mask),
        .cur_en    (status_q.ie.cur_en),
        .irq_lines (irq_lines),
        .mark_now  (delay_slot_mark),
        .mark_prev (mark_q),
        .take      (take)
    );

    irq_status_regs u_status (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .rfe_en     (rfe_en),
        .sr_wr_en   (sr_wr_en),
        .sr_wr_data (sr_wr_data),
        .take       (take),
        .status_q   (status_q)
    );

    irq_epc_reg u_epc (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .take    (take),
        .next_pc (next_pc),
        .epc_q   (epc_q)
    );

    always_comb begin
        rd_cause                            = '0;
        rd_cause[CAUSE_LSB +: IRQ_W]        = irq_lines;
    end

    assign redirect  = take;
    assign fetch_pc  = take ? HANDLER_WORD : next_pc;
    assign rd_status = sr_encode(status_q);
    assign rd_epc    = {epc_q, 2'b00};

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        hold,
    input logic [7:0]  irq_lines,
    input logic [29:0] next_pc,
    input logic        delay_slot_mark,
    input logic        sr_wr_en,
    input logic [31:0] sr_wr_data,
    input logic        rfe_en,
    input logic        redirect,
    input logic [29:0] fetch_pc,
    input logic [31:0] rd_status,
    input logic [31:0] rd_cause,
    input logic [31:0] rd_epc
);

    // R2
    entry_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (rd_status[0] && ((rd_status[15:8] & irq_lines) != 8'h00)));

    // R5
    handler_target_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (fetch_pc == 30'h0800_0030));

    // R6
    slot_block_now_chk: assert property (@(posedge clk) disable iff (rst)
        delay_slot_mark |-> !redirect);

    // R6
    slot_block_next_chk: assert property (@(posedge clk) disable iff (rst)
        (delay_slot_mark && !hold) |=> !redirect);

    // R4
    entry_saves_pc_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (rd_epc == {$past(next_pc), 2'b00}) && !rd_status[0]);

    // R11
    hold_freezes_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(rd_status) && $stable(rd_epc)));

    // R11
    hold_no_entry_chk: assert property (@(posedge clk) disable iff (rst)
        hold |-> !redirect);

endmodule

bind irq_entry_unit irq_entry_chk i_chk (.*);

// File: tb/test_irq_entry_unit.sv
`timescale 1ns/1ps
module test_irq_entry_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        hold;
    logic [7:0]  irq_lines;
    logic [29:0] next_pc;
    logic        delay_slot_mark;
    logic        sr_wr_en;
    logic [31:0] sr_wr_data;
    logic        rfe_en;
    logic        redirect;
    logic [29:0] fetch_pc;
    logic [31:0] rd_status;
    logic [31:0] rd_cause;
    logic [31:0] rd_epc;

    always #2.5 clk = ~clk;

    irq_entry_unit i_irq_entry_unit (.*);

    int n_vec  = 0;
    int n_fail = 0;

    // Reference state
    bit [7:0]  m_mask;
    bit        m_ie[3];      // 0 current, 1 previous, 2 old
    bit [29:0] m_epc;
    bit        m_mark;

    function automatic bit [31:0] exp_status();
        bit [31:0] r = 0;
        r[15:8] = m_mask;
        r[0]    = m_ie[0];
        r[2]    = m_ie[1];
        r[4]    = m_ie[2];
        return r;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit r, input bit h, input bit [7:0] irq,
                        input bit [29:0] npc, input bit mark, input bit wr,
                        input bit [31:0] wd, input bit rf, input string tag);
        bit take;
        @(negedge clk);
        rst = r; hold = h; irq_lines = irq; next_pc = npc;
        delay_slot_mark = mark; sr_wr_en = wr; sr_wr_data = wd; rfe_en = rf;
        #1;
        take = !r && !h && !mark && !m_mark && m_ie[0] && ((m_mask & irq) != 0);
        if (!r) begin
            chk(tag,  "redirect",  {31'b0, redirect}, {31'b0, take});
            chk("R5", "fetch_pc",  {2'b0, fetch_pc}, {2'b0, take ? 30'h0800_0030 : npc});
            chk(tag,  "rd_status", rd_status, exp_status());
            chk("R9", "rd_cause",  rd_cause, {16'b0, irq, 8'b0});
            chk("R10","rd_epc",    rd_epc, {m_epc, 2'b00});
        end
        @(posedge clk);
        if (r) begin
            m_mask = 0; m_ie[0] = 0; m_ie[1] = 0; m_ie[2] = 0; m_epc = 0; m_mark = 0;
        end else if (!h) begin
            if (rf) begin
                m_ie[0] = m_ie[1];
                m_ie[1] = m_ie[2];
            end
            if (wr) begin
                m_mask = wd[15:8]; m_ie[0] = wd[0]; m_ie[1] = wd[2]; m_ie[2] = wd[4];
            end
            if (take) begin
                m_ie[2] = m_ie[1];
                m_ie[1] = m_ie[0];
                m_ie[0] = 0;
                m_epc   = npc;
            end
            m_mark = mark;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        bit [31:0] lf;
        step(1, 0, 8'h00, 30'h0, 0, 0, 32'h0, 0, "R1");
        step(1, 0, 8'hFF, 30'h5, 1, 1, 32'hFFFF_FFFF, 1, "R1");
        // R1: reset state at the ports
        step(0, 0, 8'h00, 30'h10, 0, 0, 32'h0, 0, "R1");
        // R12: write enables irq while line 0 requests: no entry this cycle
        step(0, 0, 8'h01, 30'h11, 0, 1, 32'hABCD_05EB, 0, "R12");
        // R3: field mapping, garbage bits dropped; R2 unmasked line ignored
        step(0, 0, 8'h02, 30'h12, 0, 0, 32'h0, 0, "R3");
        step(0, 0, 8'h02, 30'h13, 0, 0, 32'h0, 0, "R2");
        // R11: hold blocks entry and freezes state
        step(0, 1, 8'h04, 30'h14, 0, 1, 32'h0, 1, "R11");
        step(0, 0, 8'h00, 30'h15, 0, 0, 32'h0, 0, "R11");
        // R6: delay slot and cycle after
        step(0, 0, 8'h04, 30'h16, 1, 0, 32'h0, 0, "R6");
        step(0, 0, 8'h04, 30'h17, 0, 0, 32'h0, 0, "R6");
        // R4: entry saves next_pc and pushes
        step(0, 0, 8'h04, 30'h123_4567, 0, 0, 32'h0, 0, "R4");
        step(0, 0, 8'h04, 30'h18, 0, 0, 32'h0, 0, "R4");
        // R7: return pops
        step(0, 0, 8'h00, 30'h19, 0, 0, 32'h0, 1, "R7");
        step(0, 0, 8'h00, 30'h1A, 0, 1, 32'h0000_0515, 0, "R3");
        // R7: pop and entry in the same cycle
        step(0, 0, 8'h01, 30'h3FFF_FFFF, 0, 0, 32'h0, 1, "R7");
        step(0, 0, 8'h00, 30'h1B, 0, 0, 32'h0, 1, "R7");
        // R8: write and entry in the same cycle
        step(0, 0, 8'h01, 30'h1C, 0, 1, 32'h0000_0001, 0, "R8");
        step(0, 0, 8'h01, 30'h1D, 0, 0, 32'h0, 0, "R8");
        // Mixed traffic
        lf = 32'hACE1_2345;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(0, lf[3:0] == 4'h0, lf[15:8], {lf[29:0]} ^ 30'(i),
                 lf[6:4] == 3'h0, lf[19:16] == 4'h1,
                 {lf[7:0], lf[31:8]} | 32'h0000_0001, lf[23:21] == 3'h2, "R8");
        end
        step(1, 0, 8'h00, 30'h0, 0, 0, 32'h0, 0, "R1");
        step(0, 0, 8'h00, 30'h0, 0, 0, 32'h0, 0, "R1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule